// File: doc/BRIEF.md
# Tune Sheet Command Controller

This block is the control core of a programmable tune generator. It takes decoded user commands and uses them to edit a short song. It holds three registers: a frequency divisor, a duration value and an entry pointer. A load command stores the current divisor into an eight-slot note table. The player reads that table through a combinational read port. A lower divisor gives a higher pitch, so the "up" frequency command counts the divisor down and the "down" command counts it up. No stored value is range-checked, and every register wraps modulo its width.

The controller runs on a slow system clock and acts only in cycles where `tick_en` is high. After each command it shows a four-bit display code. A play command starts a four-phase handshake with the player: `go_play` rises, stays high until the player raises `play_over`, then falls. The controller then waits for `play_over` to fall. It ignores all commands from the play command until the handshake completes.

Top module: `tune_sheet_ctrl`

## Requirements
- R1: Opcode 1 (up frequency) decrements the divisor by one and opcode 4 (down frequency) increments it by one, both modulo 2^DIV_W.
- R2: Opcode 2 (up duration) increments the duration register by one and opcode 5 (down duration) decrements it by one, both modulo 2^DUR_W.
- R3: Opcode 3 (next) increments the entry pointer by one and opcode 6 (previous) decrements it by one, modulo 2^PTR_W with no guard; previous at 0 gives all ones.
- R4: Opcode 7 (load) writes the current divisor into note slot (pointer mod 8). `rd_data` shows slot `rd_addr` in the same cycle, with no register in the path.
- R5: An accepted command sets `disp_code` on the next clock edge. The codes are: up-freq 4'hF, up-dur 4'hD, down-freq 4'hA, down-dur 4'hB, next 4'h1, previous 4'h2, load 4'h3, play 4'h4, test 4'h7. Test (opcode 9) changes nothing except the display.
- R6: An accepted play (opcode 8) makes `go_play` high from the next edge. `go_play` falls after the first enabled edge that sees `play_over` high. The block stays busy until an enabled edge sees `play_over` low.
- R7: From an accepted play until the handshake completes, commands change no register, no note slot and no display code.
- R8: A command has no effect when `tick_en` is low. Opcodes 0 and 10 to 15 never have an effect.
- R9: After a synchronous active-low reset: divisor = DIV_RST, duration = 0, pointer = 0, all note slots = 0, `disp_code` = 0, `go_play` = 0, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Clock enable for all state changes |
| cmd_vld | input | 1 | Single-cycle command strobe |
| cmd_op | input | 4 | Command opcode |
| play_over | input | 1 | Player handshake response |
| rd_addr | input | 3 | Note slot read address from player |
| go_play | output | 1 | Playback request to player |
| disp_code | output | 4 | Display code of last accepted command |
| rd_data | output | DIV_W (18) | Divisor stored in slot rd_addr |
| div_val | output | DIV_W (18) | Current divisor |
| dur_val | output | DUR_W (8) | Current duration |
| ptr_val | output | PTR_W (18) | Current entry pointer |

## Verification
The bench keeps the default widths of 18-bit divisor, 8-bit duration and 18-bit pointer. It overrides the divisor reset value to 3, so a few up-frequency commands carry the divisor through zero to all ones. The full-width pointer wraps downward with one previous command from reset. A load at that point shows that only the low three bits select the slot. Random stimulus mixes gaps in `tick_en`, invalid opcodes and player responses of varying delay, so commands also arrive during every handshake phase.

// File: rtl/tsc_pkg.sv
// Shared opcodes, display codes and handshake states for the tune sheet controller.
package tsc_pkg;

    localparam logic [3:0] OP_UPF  = 4'd1;
    localparam logic [3:0] OP_UPD  = 4'd2;
    localparam logic [3:0] OP_NEXT = 4'd3;
    localparam logic [3:0] OP_DNF  = 4'd4;
    localparam logic [3:0] OP_DND  = 4'd5;
    localparam logic [3:0] OP_PREV = 4'd6;
    localparam logic [3:0] OP_LOAD = 4'd7;
    localparam logic [3:0] OP_PLAY = 4'd8;
    localparam logic [3:0] OP_TEST = 4'd9;

    localparam logic [3:0] DSP_BLANK = 4'h0;

    typedef enum logic [1:0] {
        HS_IDLE      = 2'd0,
        HS_WAIT_DONE = 2'd1,
        HS_WAIT_CLR  = 2'd2
    } hs_state_e;

    // Returns 1 when the opcode is one of the nine defined commands.
    function automatic logic op_known(input logic [3:0] op);
        return (op >= OP_UPF) && (op <= OP_TEST);
    endfunction

    // Maps a defined opcode to its display code.
    function automatic logic [3:0] op_to_disp(input logic [3:0] op);
        case (op)
            OP_UPF:  return 4'hF;
            OP_UPD:  return 4'hD;
            OP_DNF:  return 4'hA;
            OP_DND:  return 4'hB;
            OP_NEXT: return 4'h1;
            OP_PREV: return 4'h2;
            OP_LOAD: return 4'h3;
            OP_PLAY: return 4'h4;
            OP_TEST: return 4'h7;
            default: return DSP_BLANK;
        endcase
    endfunction

endpackage

// File: rtl/tsc_play_hs.sv
// Four-phase playback handshake toward the player.
// Assumes: start is high only when idle is high and tick_en is high.
module tsc_play_hs
    import tsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic start,
    input  logic play_over,
    output logic go_play,
    output logic idle
);

    hs_state_e state_q, state_d;

    // Next-state selection for the handshake phases.
    always_comb begin
        state_d = state_q;
        if (tick_en) begin
            case (state_q)
                HS_IDLE:      if (start)      state_d = HS_WAIT_DONE;
                HS_WAIT_DONE: if (play_over)  state_d = HS_WAIT_CLR;
                HS_WAIT_CLR:  if (!play_over) state_d = HS_IDLE;
                default:                      state_d = HS_IDLE;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    assign go_play = (state_q == HS_WAIT_DONE);
    assign idle    = (state_q == HS_IDLE);

    AST_GO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (go_play && !(tick_en && play_over)) |=> go_play); // R6
    AST_GO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (go_play && tick_en && play_over) |=> (!go_play && !idle)); // R6
    AST_GO_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> go_play); // R6

endmodule

// File: rtl/tsc_regs.sv
// Divisor, duration and entry pointer registers edited by accepted commands.
// Assumes: cmd_en is already gated by tick_en and the idle state.
module tsc_regs
    import tsc_pkg::*;
#(
    parameter int DIV_W   = 18,
    parameter int DUR_W   = 8,
    parameter int PTR_W   = 18,
    parameter logic [DIV_W-1:0] DIV_RST = 1 << (DIV_W - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_en,
    input  logic [3:0]       op,
    output logic [DIV_W-1:0] div_q,
    output logic [DUR_W-1:0] dur_q,
    output logic [PTR_W-1:0] ptr_q
);

    localparam logic [DIV_W-1:0] DIV_ONE = 1;
    localparam logic [DUR_W-1:0] DUR_ONE = 1;
    localparam logic [PTR_W-1:0] PTR_ONE = 1;

    // Divisor: up-frequency lowers it, down-frequency raises it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     div_q <= DIV_RST;
        else if (cmd_en && op == OP_UPF) div_q <= div_q - DIV_ONE;
        else if (cmd_en && op == OP_DNF) div_q <= div_q + DIV_ONE;
    end

    // Duration: plain up/down counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                     dur_q <= '0;
        else if (cmd_en && op == OP_UPD) dur_q <= dur_q + DUR_ONE;
        else if (cmd_en && op == OP_DND) dur_q <= dur_q - DUR_ONE;
    end

    // Entry pointer: wraps freely in both directions.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ptr_q <= '0;
        else if (cmd_en && op == OP_NEXT) ptr_q <= ptr_q + PTR_ONE;
        else if (cmd_en && op == OP_PREV) ptr_q <= ptr_q - PTR_ONE;
    end

    AST_UPF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && op == OP_UPF) |=> div_q == $past(div_q) - DIV_ONE); // R1
    AST_DUR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && op == OP_UPD) |=> dur_q == $past(dur_q) + DUR_ONE); // R2
    AST_PREV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && op == OP_PREV) |=> ptr_q == $past(ptr_q) - PTR_ONE); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_en |=> ($stable(div_q) && $stable(dur_q) && $stable(ptr_q))); // R7

endmodule

// File: rtl/tsc_note_mem.sv
// Note table: one write port from load commands, one combinational read port.
// Assumes: NOTES is a power of two so the address is the pointer's low bits.
module tsc_note_mem #(
    parameter int NOTES = 8,
    parameter int DIV_W = 18,
    localparam int AW   = $clog2(NOTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [DIV_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DIV_W-1:0] rdata
);

    logic [DIV_W-1:0] slot_q [NOTES];

    // One register per slot, cleared on reset, written on its address.
    for (genvar g = 0; g < NOTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                            slot_q[g] <= '0;
            else if (we && waddr == AW'(g))        slot_q[g] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> slot_q[$past(waddr)] == $past(wdata)); // R4

endmodule

// File: rtl/tune_sheet_ctrl.sv
// Top of the tune sheet controller: accepts commands, edits registers,
// fills the note table and starts playback by handshake.
// Assumes: at most one command per cycle, carried by cmd_vld/cmd_op.
module tune_sheet_ctrl
    import tsc_pkg::*;
#(
    parameter int DIV_W = 18,
    parameter int DUR_W = 8,
    parameter int PTR_W = 18,
    parameter int NOTES = 8,
    parameter logic [DIV_W-1:0] DIV_RST = 1 << (DIV_W - 1),
    localparam int AW = $clog2(NOTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cmd_vld,
    input  logic [3:0]       cmd_op,
    input  logic             play_over,
    input  logic [AW-1:0]    rd_addr,
    output logic             go_play,
    output logic [3:0]       disp_code,
    output logic [DIV_W-1:0] rd_data,
    output logic [DIV_W-1:0] div_val,
    output logic [DUR_W-1:0] dur_val,
    output logic [PTR_W-1:0] ptr_val
);

    logic idle;
    logic cmd_en;
    logic known;

    assign cmd_en = tick_en && cmd_vld && idle;
    assign known  = op_known(cmd_op);

    tsc_play_hs i_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .start     (cmd_en && cmd_op == OP_PLAY),
        .play_over (play_over),
        .go_play   (go_play),
        .idle      (idle)
    );

    tsc_regs #(
        .DIV_W   (DIV_W),
        .DUR_W   (DUR_W),
        .PTR_W   (PTR_W),
        .DIV_RST (DIV_RST)
    ) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_en (cmd_en),
        .op     (cmd_op),
        .div_q  (div_val),
        .dur_q  (dur_val),
        .ptr_q  (ptr_val)
    );

    tsc_note_mem #(
        .NOTES (NOTES),
        .DIV_W (DIV_W)
    ) i_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cmd_en && cmd_op == OP_LOAD),
        .waddr (ptr_val[AW-1:0]),
        .wdata (div_val),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // Display code follows the last accepted defined command.
    always_ff @(posedge clk) begin
        if (!rst_n)               disp_code <= DSP_BLANK;
        else if (cmd_en && known) disp_code <= op_to_disp(cmd_op);
    end

    AST_TEST_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && cmd_op == OP_TEST) |=> (disp_code == 4'h7 && $stable(div_val))); // R5
    AST_BUSY_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle) |=> $stable(disp_code)); // R7
    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en) |=> ($stable(disp_code) && $stable(go_play))); // R8

endmodule

// File: tb/test_tune_sheet_ctrl.sv
// Self-checking bench: directed corners plus seeded random commands,
// compared against a behavioural model kept in the bench.
module test_tune_sheet_ctrl;

    localparam int DIV_W = 18;
    localparam int DUR_W = 8;
    localparam int PTR_W = 18;
    localparam int NOTES = 8;
    localparam logic [DIV_W-1:0] DIV_RST = 18'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic cmd_vld = 1'b0;
    logic [3:0] cmd_op = 4'd0;
    logic play_over = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic go_play;
    logic [3:0] disp_code;
    logic [DIV_W-1:0] rd_data;
    logic [DIV_W-1:0] div_val;
    logic [DUR_W-1:0] dur_val;
    logic [PTR_W-1:0] ptr_val;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [DIV_W-1:0] m_div;
    logic [DUR_W-1:0] m_dur;
    logic [PTR_W-1:0] m_ptr;
    logic [DIV_W-1:0] m_mem [NOTES];
    logic [3:0] m_disp;
    int m_st;

    always #4 clk = ~clk;

    tune_sheet_ctrl #(
        .DIV_W(DIV_W), .DUR_W(DUR_W), .PTR_W(PTR_W), .NOTES(NOTES), .DIV_RST(DIV_RST)
    ) i_tune_sheet_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cmd_vld(cmd_vld),
        .cmd_op(cmd_op), .play_over(play_over), .rd_addr(rd_addr),
        .go_play(go_play), .disp_code(disp_code), .rd_data(rd_data),
        .div_val(div_val), .dur_val(dur_val), .ptr_val(ptr_val)
    );

    function automatic logic [3:0] exp_disp(input logic [3:0] op);
        case (op)
            4'd1: return 4'hF;  4'd2: return 4'hD;  4'd3: return 4'h1;
            4'd4: return 4'hA;  4'd5: return 4'hB;  4'd6: return 4'h2;
            4'd7: return 4'h3;  4'd8: return 4'h4;  4'd9: return 4'h7;
            default: return 4'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        check("R1 divisor", 32'(div_val), 32'(m_div));
        check("R2 duration", 32'(dur_val), 32'(m_dur));
        check("R3 pointer", 32'(ptr_val), 32'(m_ptr));
        check("R4 note read", 32'(rd_data), 32'(m_mem[rd_addr]));
        check("R5 display", 32'(disp_code), 32'(m_disp));
        check("R6 go_play", 32'(go_play), 32'(m_st == 1));
    endtask

    task automatic model_reset();
        m_div = DIV_RST; m_dur = '0; m_ptr = '0; m_disp = 4'h0; m_st = 0;
        for (int i = 0; i < NOTES; i++) m_mem[i] = '0;
    endtask

    // One clock: drive at negedge, advance the model, compare after the edge.
    task automatic step(input logic v, input logic [3:0] o, input logic e, input logic po);
        logic acc;
        @(negedge clk);
        cmd_vld = v; cmd_op = o; tick_en = e; play_over = po;
        rd_addr = 3'($urandom_range(0, 7));
        acc = e && v && (m_st == 0);
        @(posedge clk);
        if (acc) begin
            case (o)
                4'd1: m_div = m_div - 1'b1;
                4'd4: m_div = m_div + 1'b1;
                4'd2: m_dur = m_dur + 1'b1;
                4'd5: m_dur = m_dur - 1'b1;
                4'd3: m_ptr = m_ptr + 1'b1;
                4'd6: m_ptr = m_ptr - 1'b1;
                4'd7: m_mem[m_ptr[2:0]] = m_div;
                4'd8: m_st = 1;
                default: ;
            endcase
            if (o >= 4'd1 && o <= 4'd9) m_disp = exp_disp(o);
        end else if (e) begin
            if (m_st == 1 && po) m_st = 2;
            else if (m_st == 2 && !po) m_st = 0;
        end
        #2;
        check_all();
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DIV_W-1:0] keep_div;
        logic [3:0] keep_disp;
        void'($urandom(32'h5EED1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R9: reset state at the ports
        check("R9 reset divisor", 32'(div_val), 32'(DIV_RST));
        check("R9 reset pointer", 32'(ptr_val), 32'd0);
        check("R9 reset display", 32'(disp_code), 32'd0);
        check("R9 reset go_play", 32'(go_play), 32'd0);
        check("R9 reset slot", 32'(rd_data), 32'd0);

        // R3: previous from zero wraps to all ones
        step(1, 4'd6, 1, 0);
        check("R3 wrap low", 32'(ptr_val), 32'h3FFFF);
        // R4: load at all-ones pointer lands in slot 7
        step(1, 4'd7, 1, 0);
        @(negedge clk); rd_addr = 3'd7; #1;
        check("R4 slot7", 32'(rd_data), 32'(DIV_RST));
        step(1, 4'd3, 1, 0);
        check("R3 wrap high", 32'(ptr_val), 32'd0);
        // R1: divisor down through zero to all ones
        repeat (4) step(1, 4'd1, 1, 0);
        check("R1 wrap", 32'(div_val), 32'h3FFFF);
        step(1, 4'd4, 1, 0);
        check("R1 up from ones", 32'(div_val), 32'd0);
        // R2: duration below zero
        step(1, 4'd5, 1, 0);
        check("R2 wrap", 32'(dur_val), 32'hFF);
        // R8: gated cycle and undefined opcode
        keep_disp = disp_code;
        step(1, 4'd3, 0, 0);
        check("R8 gated pointer", 32'(ptr_val), 32'd0);
        step(1, 4'd12, 1, 0);
        check("R8 bad op display", 32'(disp_code), 32'(keep_disp));
        // R5: test touches only the display
        keep_div = div_val;
        step(1, 4'd9, 1, 0);
        check("R5 test display", 32'(disp_code), 32'h7);
        check("R5 test divisor", 32'(div_val), 32'(keep_div));
        // R6 / R7: play, then commands while busy are dropped
        step(1, 4'd8, 1, 0);
        check("R6 go_play up", 32'(go_play), 32'd1);
        step(1, 4'd4, 1, 0);
        check("R7 busy divisor", 32'(div_val), 32'(keep_div));
        check("R7 busy display", 32'(disp_code), 32'h4);
        step(0, 4'd0, 1, 1);
        check("R6 go_play down", 32'(go_play), 32'd0);
        step(1, 4'd4, 1, 1);
        check("R7 wait-clear divisor", 32'(div_val), 32'(keep_div));
        step(0, 4'd0, 1, 0);
        step(1, 4'd4, 1, 0);
        check("R6 idle again", 32'(div_val), 32'(keep_div + 1'b1));

        // Random mix of commands, enables and player responses
        for (int i = 0; i < 4000; i++) begin
            logic v, e, po;
            logic [3:0] o;
            v  = ($urandom_range(0, 9) < 7);
            e  = ($urandom_range(0, 9) < 8);
            o  = 4'($urandom_range(0, 15));
            if (o > 4'd9 && $urandom_range(0, 3) != 0) o = 4'($urandom_range(1, 9));
            po = (m_st == 1) ? ($urandom_range(0, 3) == 0)
               : (m_st == 2) ? ($urandom_range(0, 1) == 0) : 1'b0;
            step(v, o, e, po);
        end

        // R9: reset in mid-run returns everything to the initial state
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        model_reset();
        @(negedge clk); rst_n = 1'b1; rd_addr = 3'd0;
        #1;
        check("R9 re-reset divisor", 32'(div_val), 32'(DIV_RST));
        check("R9 re-reset slot", 32'(rd_data), 32'd0);
        check("R9 re-reset go_play", 32'(go_play), 32'd0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule